// File: doc/BRIEF.md
# UART Serial Framer with Parity and Line Break

This block turns parallel words into asynchronous serial frames on a transmit line and recovers words from a receive line. It runs from a clock-enable pulse at sixteen times the bit rate. A bit period is therefore sixteen such pulses. Data can be 7, 8 or 9 bits wide. In the shorter formats an optional odd or even parity bit follows the data. The receiver reports parity and framing faults with each word.

The framer has two further modes besides normal operation. In attention mode every frame carries nine data bits, and the receiver keeps only frames whose ninth bit is set. This suits address-tagged traffic on a shared line. In loopback mode the transmitter feeds the receiver internally while the external line stays idle. A control input forces the transmit line low to send a line break. The receiver flags an incoming break when the line stays low well past a frame that ended without a stop bit.

Top module: `uart_framer`

## Requirements
- R1: After reset, txd is 1, tx_busy is 0, and rx_valid, par_err, frm_err and brk_det are all 0.
- R2: A frame is a 0 start bit, then the data bits LSB first, then an optional parity bit, then one 1 stop bit. Each bit lasts 16 tick pulses. fmt 2'b00 selects 7 data bits, 2'b01 selects 8 and 2'b1x selects 9. Bits of tx_data above the selected width are not sent.
- R3: In normal mode (mode 2'b00 or 2'b11) with 7 or 8 data bits and par_en set, par_sel 2'b01 appends odd parity and 2'b10 appends even parity. par_sel 2'b00 or 2'b11 adds no parity bit.
- R4: No parity bit is sent or expected with 9 data bits, in attention mode (mode 2'b01) or in loopback mode (mode 2'b10), whatever par_en and par_sel are.
- R5: The receiver samples each bit at its middle. At the stop bit it pulses rx_valid for one cycle with the word in rx_data, zero-extended. par_err is raised with rx_valid when a parity bit was expected and does not match.
- R6: A stop bit sampled as 0 raises frm_err together with rx_valid.
- R7: After a missing stop bit, brk_det rises once the line has stayed low for 10 more bit times. It falls when the line returns high. If the line goes high earlier, the count starts again from zero.
- R8: While brk_req is 1 and no frame is in progress, txd is held at 0 and tx_busy is 1. A frame already in progress completes first. After brk_req drops, txd returns to 1.
- R9: In loopback mode the external txd stays 1, and the receiver decodes the internally transmitted frames.
- R10: Attention mode sends and receives 9 data bits regardless of fmt. A received frame with a valid stop bit and ninth bit 0 produces no rx_valid.
- R11: tx_valid is ignored while tx_busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable pulse at 16 times the bit rate |
| fmt | input | 2 | Data width: 00 = 7, 01 = 8, 1x = 9 |
| par_en | input | 1 | Parity on |
| par_sel | input | 2 | 01 = odd, 10 = even, other values = none |
| mode | input | 2 | 00/11 = normal, 01 = attention, 10 = loopback |
| brk_req | input | 1 | Hold the transmit line low |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | Load tx_data when not busy |
| tx_busy | output | 1 | A frame or a break is in progress |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| par_err | output | 1 | Parity mismatch, valid with rx_valid |
| frm_err | output | 1 | Missing stop bit, valid with rx_valid |
| brk_det | output | 1 | Incoming break detected |

## Verification
The hardest behaviour to reach is the reset of the break counter. From outside it is only visible as a brk_det that fails to rise. To reach it, the bench drops the line for a full frame so the stop bit is missed, and holds it low for several more bit times. It then releases the line for one bit and pulls it low again. This starts a second all-zero frame. The bench then checks brk_det at a point that would be past the threshold if the first count had been kept. A separate sustained-low run confirms that brk_det stays 0 just before the ten-bit threshold and is 1 just after it.

// File: rtl/uart_framer.sv
`timescale 1ns/1ps
module uart_framer #(
  parameter int DW = 9,
  parameter int OVS = 16,
  parameter int MID = 8,
  parameter int BRK_BITS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    fmt,
  input  logic          par_en,
  input  logic [1:0]    par_sel,
  input  logic [1:0]    mode,
  input  logic          brk_req,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_busy,
  output logic          txd,
  input  logic          rxd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          par_err,
  output logic          frm_err,
  output logic          brk_det
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int LW = $clog2(FW + 1);
  localparam int BRK_TICKS = OVS * BRK_BITS;
  localparam int BCW = $clog2(BRK_TICKS);

  typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_BRK} tx_st_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_BRK} rx_st_t;

  logic loop, attn, par_on, par_odd, par_bit;
  int nb;
  logic [DW-1:0] dmask;
  logic [FW-1:0] frame;

  assign loop = (mode == 2'b10);
  assign attn = (mode == 2'b01);
  assign par_odd = (par_sel == 2'b01);
  assign par_on = par_en && (par_sel == 2'b01 || par_sel == 2'b10) && !loop && !attn && !fmt[1];

  always_comb begin
    nb = (attn || fmt[1]) ? DW : (fmt[0] ? DW - 1 : DW - 2);
    for (int i = 0; i < DW; i++) dmask[i] = (i < nb);
    par_bit = (^(tx_data & dmask)) ^ par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) if (dmask[i]) frame[i+1] = tx_data[i];
    for (int i = 0; i < FW; i++) if (par_on && i == nb + 1) frame[i] = par_bit;
  end

  // transmitter
  tx_st_t tx_st;
  logic [FW-1:0] tx_sh;
  logic [LW-1:0] tx_left;
  logic [CW-1:0] tx_cnt;
  logic txd_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st <= T_IDLE;
      tx_sh <= '1;
      tx_left <= '0;
      tx_cnt <= '0;
    end else begin
      case (tx_st)
        T_IDLE:
          if (brk_req) tx_st <= T_BRK;
          else if (tx_valid) begin
            tx_sh <= frame;
            tx_left <= LW'(nb + 2 + (par_on ? 1 : 0));
            tx_cnt <= '0;
            tx_st <= T_SHIFT;
          end
        T_SHIFT:
          if (tick) begin
            if (tx_cnt == CW'(OVS - 1)) begin
              tx_cnt <= '0;
              if (tx_left == LW'(1)) begin
                tx_st <= T_IDLE;
                tx_sh <= '1;
              end else begin
                tx_sh <= {1'b1, tx_sh[FW-1:1]};
                tx_left <= tx_left - LW'(1);
              end
            end else tx_cnt <= tx_cnt + CW'(1);
          end
        T_BRK:
          if (!brk_req) tx_st <= T_IDLE;
        default: tx_st <= T_IDLE;
      endcase
    end
  end

  assign txd_int = (tx_st == T_BRK) ? 1'b0 : tx_sh[0];
  assign txd = loop | txd_int;
  assign tx_busy = (tx_st != T_IDLE);

  // receiver
  rx_st_t rx_st;
  logic [1:0] rsync;
  logic rline;
  logic [CW-1:0] rx_cnt;
  logic [LW-1:0] rx_idx, r_tot, r_nb;
  logic [DW-1:0] r_mask, rx_dm;
  logic r_par, r_odd, r_attn, rx_pbad;
  logic [DW:0] rx_sh;
  logic [BCW-1:0] brk_cnt;

  assign rline = loop ? txd_int : rsync[1];
  assign rx_dm = rx_sh[DW-1:0] & r_mask;
  assign rx_pbad = r_par && (rx_sh[r_nb] != ((^rx_dm) ^ r_odd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsync <= 2'b11;
      rx_st <= R_IDLE;
      rx_cnt <= '0;
      rx_idx <= '0;
      r_tot <= '0;
      r_nb <= '0;
      r_mask <= '0;
      r_par <= 1'b0;
      r_odd <= 1'b0;
      r_attn <= 1'b0;
      rx_sh <= '0;
      brk_cnt <= '0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      brk_det <= 1'b0;
    end else begin
      rsync <= {rsync[0], rxd};
      rx_valid <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      if (tick) begin
        case (rx_st)
          R_IDLE:
            if (!rline) begin
              rx_st <= R_START;
              rx_cnt <= CW'(1);
            end
          R_START:
            if (rx_cnt == CW'(MID - 1)) begin
              rx_cnt <= '0;
              if (!rline) begin
                rx_st <= R_DATA;
                rx_idx <= '0;
                rx_sh <= '0;
                r_tot <= LW'(nb + (par_on ? 1 : 0));
                r_nb <= LW'(nb);
                r_mask <= dmask;
                r_par <= par_on;
                r_odd <= par_odd;
                r_attn <= attn;
              end else rx_st <= R_IDLE;
            end else rx_cnt <= rx_cnt + CW'(1);
          R_DATA:
            if (rx_cnt == CW'(OVS - 1)) begin
              rx_cnt <= '0;
              rx_sh[rx_idx] <= rline;
              if (rx_idx == r_tot - LW'(1)) rx_st <= R_STOP;
              else rx_idx <= rx_idx + LW'(1);
            end else rx_cnt <= rx_cnt + CW'(1);
          R_STOP:
            if (rx_cnt == CW'(OVS - 1)) begin
              rx_cnt <= '0;
              if (rline) begin
                rx_st <= R_IDLE;
                if (!(r_attn && !rx_sh[DW-1])) begin
                  rx_valid <= 1'b1;
                  rx_data <= rx_dm;
                  par_err <= rx_pbad;
                end
              end else begin
                rx_st <= R_BRK;
                brk_cnt <= '0;
                rx_valid <= 1'b1;
                rx_data <= rx_dm;
                par_err <= rx_pbad;
                frm_err <= 1'b1;
              end
            end else rx_cnt <= rx_cnt + CW'(1);
          R_BRK:
            if (rline) begin
              rx_st <= R_IDLE;
              brk_det <= 1'b0;
            end else if (brk_cnt == BCW'(BRK_TICKS - 1)) brk_det <= 1'b1;
            else brk_cnt <= brk_cnt + BCW'(1);
          default: rx_st <= R_IDLE;
        endcase
      end
    end
  end

  p_shift_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == T_SHIFT && !tick) |=> $stable(tx_sh) && $stable(tx_left));
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == T_SHIFT && tx_valid && !tick) |=> (tx_st == T_SHIFT) && $stable(tx_sh));
  p_rxv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_frm_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> rx_valid);
  p_brk_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> $past(rx_st == R_BRK) && !$past(rline));
  p_brk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == T_BRK && brk_req) |=> (tx_st == T_BRK) && !txd_int);
endmodule

// File: tb/uart_framer_test.sv
`timescale 1ns/1ps
module uart_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] fmt = 2'b01;
  logic par_en = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic [1:0] mode = 2'b00;
  logic brk_req = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_busy, txd;
  logic rxd = 1'b1;
  logic [8:0] rx_data;
  logic rx_valid, par_err, frm_err, brk_det;
  logic [1:0] div = '0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) begin
    div <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  uart_framer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .par_en(par_en),
    .par_sel(par_sel), .mode(mode), .brk_req(brk_req), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
    .frm_err(frm_err), .brk_det(brk_det)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] f, input logic pe, input logic [1:0] ps, input logic [1:0] m);
    fmt = f; par_en = pe; par_sel = ps; mode = m;
  endtask

  task automatic build(input logic [8:0] d, input int nb, input bit par, input bit odd,
                       output logic [11:0] fr, output int len);
    bit p = 1'b0;
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      fr[i+1] = d[i];
      p = p ^ d[i];
    end
    if (par) fr[nb+1] = p ^ odd;
    len = nb + 2 + (par ? 1 : 0);
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic grab_tx(output logic [11:0] bits);
    int w = 0;
    while (txd !== 1'b0 && w < 2000) begin
      @(negedge clk);
      w++;
    end
    repeat (32) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < 12; k++) begin
      repeat (64) @(negedge clk);
      bits[k] = txd;
    end
  endtask

  task automatic drive_rx(input logic [11:0] fr, input int len);
    for (int k = 0; k < len; k++) begin
      rxd = fr[k];
      repeat (64) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic watch_rx(input int cyc, output bit got, output logic [8:0] d,
                          output bit pe, output bit fe);
    got = 1'b0; d = '0; pe = 1'b0; fe = 1'b0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (rx_valid && !got) begin
        got = 1'b1; d = rx_data; pe = par_err; fe = frm_err;
      end
    end
  endtask

  // frame on txd, with a second tx_valid pushed mid-frame (R11)
  task automatic tx_case(input string req, input logic [8:0] d, input int nb, input bit par, input bit odd);
    logic [11:0] exp, got;
    int len;
    build(d, nb, par, odd, exp, len);
    fork
      send(d);
      grab_tx(got);
      begin
        repeat (200) @(negedge clk);
        tx_data = ~d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
      end
    join
    chk(req, "tx frame bits", int'(got), int'(exp));
    chk("R11", "busy after frame", int'(tx_busy), 0);
    repeat (64) @(negedge clk);
  endtask

  task automatic rx_case(input string req, input logic [11:0] fr, input int len, input bit exp_got,
                         input logic [8:0] exp_d, input bit exp_pe, input bit exp_fe);
    bit got, pe, fe;
    logic [8:0] d;
    fork
      drive_rx(fr, len);
      watch_rx(len * 64 + 96, got, d, pe, fe);
    join
    chk(req, "rx_valid seen", int'(got), int'(exp_got));
    if (exp_got) begin
      chk(req, "rx_data", int'(d), int'(exp_d));
      chk(req, "par_err", int'(pe), int'(exp_pe));
      chk(req, "frm_err", int'(fe), int'(exp_fe));
    end
    repeat (64) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "txd", int'(txd), 1);
    chk("R1", "tx_busy", int'(tx_busy), 0);
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "errors", int'({par_err, frm_err}), 0);
    chk("R1", "brk_det", int'(brk_det), 0);
  endtask

  task automatic t_tx_formats;
    cfg(2'b01, 1'b0, 2'b00, 2'b00);
    tx_case("R2", 9'h1A5, 8, 1'b0, 1'b0);
    cfg(2'b00, 1'b0, 2'b00, 2'b00);
    tx_case("R2", 9'h1F3, 7, 1'b0, 1'b0);
    cfg(2'b00, 1'b1, 2'b01, 2'b00);
    tx_case("R3", 9'h035, 7, 1'b1, 1'b1);
    cfg(2'b01, 1'b1, 2'b10, 2'b00);
    tx_case("R3", 9'h07F, 8, 1'b1, 1'b0);
    cfg(2'b01, 1'b1, 2'b00, 2'b00);
    tx_case("R3", 9'h0C4, 8, 1'b0, 1'b0);
    cfg(2'b10, 1'b1, 2'b10, 2'b00);
    tx_case("R4", 9'h0F3, 9, 1'b0, 1'b0);
  endtask

  task automatic t_rx_basic;
    logic [11:0] fr;
    int len;
    cfg(2'b01, 1'b1, 2'b10, 2'b00);
    build(9'h096, 8, 1'b1, 1'b0, fr, len);
    rx_case("R5", fr, len, 1'b1, 9'h096, 1'b0, 1'b0);
    fr[9] = ~fr[9];
    rx_case("R5", fr, len, 1'b1, 9'h096, 1'b1, 1'b0);
    cfg(2'b00, 1'b0, 2'b00, 2'b00);
    build(9'h055, 7, 1'b0, 1'b0, fr, len);
    rx_case("R5", fr, len, 1'b1, 9'h055, 1'b0, 1'b0);
    cfg(2'b10, 1'b1, 2'b01, 2'b00);
    build(9'h1C3, 9, 1'b0, 1'b0, fr, len);
    rx_case("R4", fr, len, 1'b1, 9'h1C3, 1'b0, 1'b0);
  endtask

  task automatic t_rx_break;
    bit got, pe, fe;
    logic [8:0] d;
    cfg(2'b01, 1'b0, 2'b00, 2'b00);
    @(negedge clk);
    rxd = 1'b0;
    watch_rx(11 * 64, got, d, pe, fe);
    chk("R6", "framing flagged", int'({got, fe}), 3);
    repeat (7 * 64) @(negedge clk);
    chk("R7", "no break before 10 bits", int'(brk_det), 0);
    repeat (3 * 64) @(negedge clk);
    chk("R7", "break after 10 bits", int'(brk_det), 1);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    chk("R7", "break clears on high", int'(brk_det), 0);
    repeat (128) @(negedge clk);
  endtask

  task automatic t_rx_break_restart;
    cfg(2'b01, 1'b0, 2'b00, 2'b00);
    @(negedge clk);
    rxd = 1'b0;
    repeat (15 * 64) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    rxd = 1'b0;
    repeat (14 * 64) @(negedge clk);
    chk("R7", "count restarts after high", int'(brk_det), 0);
    rxd = 1'b1;
    repeat (192) @(negedge clk);
  endtask

  task automatic t_tx_break;
    logic [11:0] exp, got;
    int len;
    cfg(2'b01, 1'b0, 2'b00, 2'b00);
    build(9'h05A, 8, 1'b0, 1'b0, exp, len);
    exp[11:10] = 2'b00;
    fork
      send(9'h05A);
      grab_tx(got);
      begin
        repeat (100) @(negedge clk);
        brk_req = 1'b1;
      end
    join
    chk("R8", "frame then break", int'(got), int'(exp));
    chk("R8", "busy in break", int'(tx_busy), 1);
    tx_data = 9'h0FF;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (200) @(negedge clk);
    chk("R8", "line held low", int'(txd), 0);
    brk_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "line high after release", int'({txd, tx_busy}), 2);
    repeat (100) @(negedge clk);
    chk("R11", "no frame from load during break", int'({txd, tx_busy}), 2);
    brk_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "idle break low", int'(txd), 0);
    brk_req = 1'b0;
    repeat (64) @(negedge clk);
  endtask

  task automatic t_loopback;
    bit got, pe, fe;
    bit low_seen = 1'b0;
    logic [8:0] d;
    cfg(2'b01, 1'b1, 2'b01, 2'b10);
    fork
      send(9'h03C);
      watch_rx(14 * 64, got, d, pe, fe);
      for (int k = 0; k < 14 * 64; k++) begin
        @(negedge clk);
        if (txd !== 1'b1) low_seen = 1'b1;
      end
    join
    chk("R9", "external line idle", int'(low_seen), 0);
    chk("R9", "looped word", int'({got, d}), int'({1'b1, 9'h03C}));
    chk("R4", "no parity error in loopback", int'({pe, fe}), 0);
    repeat (64) @(negedge clk);
  endtask

  task automatic t_attention;
    logic [11:0] fr;
    int len;
    cfg(2'b00, 1'b1, 2'b10, 2'b01);
    tx_case("R10", 9'h1A5, 9, 1'b0, 1'b0);
    build(9'h0A5, 9, 1'b0, 1'b0, fr, len);
    rx_case("R10", fr, len, 1'b0, 9'h000, 1'b0, 1'b0);
    build(9'h15A, 9, 1'b0, 1'b0, fr, len);
    rx_case("R10", fr, len, 1'b1, 9'h15A, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx_formats();
    t_rx_basic();
    t_rx_break();
    t_rx_break_restart();
    t_tx_break();
    t_loopback();
    t_attention();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule